// File: doc/BRIEF.md
# Gated Clock Post-Divider

This block divides a fast oscillator clock by 1, 2, 4 or 8 and drives the result as a complementary pair of outputs. A 2-bit select picks the ratio. An active-high enable turns the output on and off. The enable is retimed inside the block and only acts while the output is low, so starting or stopping the output never produces a shortened high pulse. When the output is stopped, the true side rests low and the complement side rests high.

The block runs on `clk`, a tick clock at twice the oscillator rate, so one tick is one half-period of the oscillator. Every output is a plain register in that domain, which gives one timing model for all four ratios. With ratio R, each output level lasts R ticks. The output frequency is therefore the oscillator frequency divided by R. With a 200 to 400 MHz oscillator, the four codes cover 200–400, 100–200, 50–100 and 25–50 MHz.

A change of select restarts the internal phase counter, so the new ratio starts from a clean count. A synchronous active-high reset clears the counter and parks the output low.

Top module: `pdiv_gated`

## Requirements
- R1: With `sel` = 2'b00 and the output enabled, `fout_p` changes level on every tick, so each high and each low level lasts 1 tick (divide-by-1).
- R2: With `sel` = 2'b01, 2'b10 or 2'b11 and the output enabled, each high level and each low level of `fout_p` lasts 2, 4 or 8 ticks respectively (ratio R = 2^sel).
- R3: While `rst` is high at a rising edge of `clk`, `fout_p` is 0 and `fout_n` is 1 after that edge.
- R4: `fout_n` is always the inverse of `fout_p`.
- R5: Every high level of `fout_p` lasts exactly R ticks, including the last pulse before a stop and the first pulse after a start.
- R6: After `oe` falls, `fout_p` is low and `fout_n` high within SYNC_STAGES + 2R + 2 ticks, and they stay there while `oe` remains low.
- R7: After `oe` rises, from a stopped output, the first rising edge of `fout_p` comes within SYNC_STAGES + R + 1 ticks. No low level before a rising edge is shorter than R ticks.
- R8: A change of `sel` restarts the phase counter. From the second pulse after the change, every high level has the new width R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per oscillator half-period |
| rst | input | 1 | Synchronous active-high reset |
| oe | input | 1 | Output enable, active high, asynchronous to the output phase |
| sel | input | SEL_W | Ratio select, R = 2^sel |
| fout_p | output | 1 | True side of the divided clock |
| fout_n | output | 1 | Complement side of the divided clock |

## Verification
The enable passes through SYNC_STAGES flops and then waits for the next terminal count while the output is low. A start or stop can therefore take effect up to SYNC_STAGES + R + 1 ticks after `oe` changes, or up to SYNC_STAGES + 2R + 2 ticks when a full high pulse must finish first. The checks on stop and start wait for exactly those bounds before they sample. Pulse widths are measured edge to edge on the falling clock edge, one half-tick after each register update. Measurement starts only after the first complete level that follows a select change or a re-arm, so a partial level is never judged. Reset and complement are checked at the first falling edge after the stimulus.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  // terminal count of the phase counter for a ratio of 2^sel ticks
  function automatic int unsigned term_count(input int unsigned sel);
    return (1 << sel) - 1;
  endfunction
endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdiv_count.sv
module pdiv_count
  import pdiv_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] sel_q,
  output logic [CNT_W-1:0] cnt,
  output logic             term
);
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(term_count(int'(sel_q)));
    term = (sel == sel_q) && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt   <= '0;
    end else if (sel != sel_q) begin
      sel_q <= sel;
      cnt   <= '0;
    end else if (cnt == last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdiv_outreg.sv
module pdiv_outreg (
  input  logic clk,
  input  logic rst,
  input  logic term,
  input  logic en,
  output logic out_p,
  output logic out_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_p <= 1'b0;
      out_n <= 1'b1;
    end else if (term) begin
      if (out_p) begin
        out_p <= 1'b0;
        out_n <= 1'b1;
      end else begin
        out_p <= en;
        out_n <= ~en;
      end
    end
  end
endmodule

// File: rtl/pdiv_gated.sv
module pdiv_gated #(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe,
  input  logic [SEL_W-1:0] sel,
  output logic             fout_p,
  output logic             fout_n
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic             oe_s;
  logic             term;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt;

  pdiv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(oe), .q(oe_s)
  );

  pdiv_count #(.SEL_W(SEL_W), .CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .sel(sel), .sel_q(sel_q), .cnt(cnt), .term(term)
  );

  pdiv_outreg out_i (
    .clk(clk), .rst(rst), .term(term), .en(oe_s),
    .out_p(fout_p), .out_n(fout_n)
  );
endmodule

// File: rtl/pdiv_gated_chk.sv
module pdiv_gated_chk #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_s,
  input logic             term,
  input logic [SEL_W-1:0] sel,
  input logic [SEL_W-1:0] sel_q,
  input logic [CNT_W-1:0] cnt,
  input logic             fout_p,
  input logic             fout_n
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= ~rst;

  // R4
  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    primed |-> (fout_n == ~fout_p));

  // R3
  a_r3_reset_low: assert property (@(posedge clk)
    rst |=> (!fout_p && fout_n));

  // R7: a rising edge needs the retimed enable
  a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (primed && $rose(fout_p)) |-> $past(oe_s));

  // R5: the output moves only on a terminal count
  a_r5_move_on_term: assert property (@(posedge clk) disable iff (rst)
    (primed && !$stable(fout_p)) |-> $past(term));

  // R8: a select change restarts the counter
  a_r8_sel_restart: assert property (@(posedge clk) disable iff (rst)
    (primed && (sel != sel_q)) |=> (cnt == '0));
endmodule

bind pdiv_gated pdiv_gated_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .oe_s(oe_s), .term(term), .sel(sel),
  .sel_q(sel_q), .cnt(cnt), .fout_p(fout_p), .fout_n(fout_n)
);

// File: tb/pdiv_gated_tb_top.sv
`timescale 1ns/1ps
module pdiv_gated_tb_top;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       oe  = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       fout_p, fout_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // width monitor state
  bit chk_on = 1'b0;
  bit armed  = 1'b0;
  int exp_r  = 1;
  int run    = 0;
  bit prev_p = 1'b0;
  int highs  = 0;

  always #4 clk = ~clk;

  pdiv_gated #(.SEL_W(2), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .oe(oe), .sel(sel),
    .fout_p(fout_p), .fout_n(fout_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // the monitor runs on the falling edge, half a tick after each update
  always @(negedge clk) begin
    if (!rst) begin
      check(fout_n == ~fout_p, "R4 complement", int'(fout_n), int'(~fout_p));
      if (fout_p == prev_p) begin
        run++;
      end else begin
        if (chk_on && armed) begin
          if (!fout_p) begin
            // R1 / R2 / R5: high level width
            check(run == exp_r, "R5 high width (R1/R2)", run, exp_r);
            highs++;
          end else begin
            // R7: no short low level
            check(run >= exp_r, "R7 low width", run, exp_r);
          end
        end
        if (chk_on) armed = 1'b1;
        run = 1;
      end
      prev_p = fout_p;
    end else begin
      run = 0;
      prev_p = 1'b0;
    end
  end

  task automatic arm(input int r);
    chk_on = 1'b1;
    armed  = 1'b0;
    exp_r  = r;
  endtask

  initial begin
    ticks(3);
    check(fout_p == 1'b0 && fout_n == 1'b1, "R3 reset state", int'(fout_p), 0);
    rst = 1'b0;

    // sweep of ratios and of stop phases
    for (int s = 0; s < 4; s++) begin
      int r;
      r = 1 << s;
      chk_on = 1'b0;
      sel = 2'(s);
      oe  = 1'b1;
      ticks(24);
      arm(r);
      highs = 0;
      ticks(8 * r + 4);
      check(highs >= 3, (s == 0) ? "R1 pulses seen" : "R2 pulses seen", highs, 3);
      for (int off = 0; off < 2 * r; off++) begin
        int wait_t;
        bit low_all;
        ticks(off);
        oe = 1'b0;
        ticks(SYNC + 2 * r + 2);
        check(fout_p == 1'b0 && fout_n == 1'b1, "R6 stopped low", int'(fout_p), 0);
        low_all = 1'b1;
        for (int k = 0; k < 16; k++) begin
          ticks(1);
          if (fout_p) low_all = 1'b0;
        end
        check(low_all, "R6 stays low", int'(!low_all), 0);
        oe = 1'b1;
        wait_t = 0;
        while (!fout_p && wait_t < 64) begin
          ticks(1);
          wait_t++;
        end
        check(wait_t <= SYNC + r + 1, "R7 start latency", wait_t, SYNC + r + 1);
        ticks(4 * r + 2);
      end
    end

    // select change: every pair of old and new codes
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          chk_on = 1'b0;
          sel = 2'(a);
          ticks(24);
          sel = 2'(b);
          ticks(3);
          arm(1 << b);
          highs = 0;
          ticks(8 * (1 << b) + 6);
          check(highs >= 2, "R8 new ratio pulses", highs, 2);
        end
      end
    end

    // reset in mid-run
    chk_on = 1'b0;
    sel = 2'b10;
    oe  = 1'b1;
    ticks(21);
    rst = 1'b1;
    ticks(1);
    check(fout_p == 1'b0 && fout_n == 1'b1, "R3 reset mid-run", int'(fout_p), 0);
    ticks(3);
    check(fout_p == 1'b0 && fout_n == 1'b1, "R3 reset held", int'(fout_p), 0);
    rst = 1'b0;
    ticks(30);
    check(highs >= 0 && fout_n == ~fout_p, "R4 after reset", int'(fout_n), int'(~fout_p));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule